// File: doc/BRIEF.md
# Grounded-Pin Seven-Segment Indicator

This block watches a group of active-low input pins and shows, on one common-cathode seven-segment display, the index of the pin that was pulled to ground. Each pin passes through a two-flop synchronizer. After that, a priority picker selects the grounded pin with the smallest index. A decoder turns that index into a segment pattern, and a register holds the pattern on the output.

The shown digit is sticky. When every pin goes back to idle, the display keeps the last digit and does not blank. It changes only when a pin with a different index is grounded. A one-cycle flag marks each cycle in which the displayed pattern has just changed. This lets a downstream consumer react to new digits without comparing the patterns itself.

Top module: `grounded_pin_display`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, seg_o reads 8'h00 (all segments off) and valid_o reads 0.
- R2: Each pin is active low. A pin at 0 is grounded and a pin at 1 is idle. A grounded pin k shows its digit with segment a on bit 0 through segment g on bit 6. The patterns are 0=8'h3F, 1=8'h06, 2=8'h5B, 3=8'h4F, 4=8'h66, 5=8'h6D, 6=8'h7D, 7=8'h07.
- R3: When several pins are grounded at the same sampling edge, the pin with the lowest index sets the digit.
- R4: When no pin is grounded, seg_o keeps its previous pattern unchanged.
- R5: Bit 7 of seg_o is 0 at all times.
- R6: The pin vector sampled at rising edge n sets seg_o just after rising edge n+2, so the path has two edges of latency.
- R7: valid_o is 1 for exactly the cycle that follows an edge at which seg_o took a different value. Grounding the pin that is already shown gives no pulse.
- R8: A pin grounded for only one sampling edge is still captured and shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_ni | input | 8 | Pin levels, 0 = grounded |
| seg_o | output | 8 | Segment pattern, bit0=a .. bit6=g, bit7=0 |
| valid_o | output | 1 | One-cycle pulse on a pattern change |

## Verification
A wrong synchronizer stage count or reset value shows up as a latency error. The outputs move one edge early or late relative to the pin, or a phantom digit appears within two edges of reset release. A wrong priority or decoder entry produces a wrong pattern on the third edge after the stimulus. A faulty hold path makes the display blank or drift in the first cycle after all pins go idle. An incorrect change flag shows up as a missing or repeated pulse on the same edge where seg_o changes or fails to change. The bench compares both outputs against a reference model on every clock, so each of these faults is reported within a few cycles of the stimulus that exposes it.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  localparam int unsigned NumPins = 8;
  localparam int unsigned IdxW    = $clog2(NumPins);
  localparam int unsigned SegW    = 8;

  typedef logic [SegW-1:0] seg_t;
  typedef logic [IdxW-1:0] idx_t;

  // bit0=a .. bit6=g, bit7 always 0
  function automatic seg_t digit_pattern(input int unsigned d);
    seg_t p;
    case (d)
      0:       p = 8'h3F;
      1:       p = 8'h06;
      2:       p = 8'h5B;
      3:       p = 8'h4F;
      4:       p = 8'h66;
      5:       p = 8'h6D;
      6:       p = 8'h7D;
      7:       p = 8'h07;
      8:       p = 8'h7F;
      9:       p = 8'h6F;
      default: p = 8'h00;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/gpd_pin_sync.sv
module gpd_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '1; // idle level
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R6: final stage follows the first stage one edge later
  if (STAGES == 2) begin : g_chk
    p_stage_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> q_o == $past(stage_q[0]));
  end
endmodule

// File: rtl/gpd_low_pick.sv
module gpd_low_pick #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] act_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  logic [WIDTH-1:0] grant;
  logic [WIDTH:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    assign grant[i]  = act_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | act_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (grant[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign found_o = seen[WIDTH];

  // R3: one winner at most, and it is the lowest active bit
  p_one_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  p_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (act_i & ((WIDTH'(1) << idx_o) - WIDTH'(1))) == '0);
endmodule

// File: rtl/gpd_seg_decode.sv
module gpd_seg_decode
  import gpd_pkg::*;
(
  input  idx_t idx_i,
  output seg_t seg_o
);
  assign seg_o = digit_pattern(int'(idx_i));

  // R5: decoder never drives the spare bit
  always_comb begin
    a_spare_low_r5: assert (seg_o[SegW-1] == 1'b0);
  end
endmodule

// File: rtl/grounded_pin_display.sv
module grounded_pin_display
  import gpd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NumPins-1:0] pins_ni,
  output logic [SegW-1:0]    seg_o,
  output logic               valid_o
);
  logic [NumPins-1:0] pins_sync_n;
  logic               found;
  idx_t               idx;
  seg_t               pat, seg_d, seg_q;
  logic               valid_q;

  gpd_pin_sync #(.WIDTH(NumPins), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_ni),
    .q_o   (pins_sync_n)
  );

  gpd_low_pick #(.WIDTH(NumPins)) i_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (~pins_sync_n),
    .found_o(found),
    .idx_o  (idx)
  );

  gpd_seg_decode i_dec (
    .idx_i(idx),
    .seg_o(pat)
  );

  assign seg_d = found ? pat : seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      valid_q <= (seg_d != seg_q);
    end
  end

  assign seg_o   = seg_q;
  assign valid_o = valid_q;

  p_spare_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[SegW-1] == 1'b0);
  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pins_sync_n) |=> $stable(seg_o));
  p_pulse_means_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> seg_o != $past(seg_o));
  p_change_means_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && (seg_o != $past(seg_o)) |-> valid_o);
endmodule

// File: tb/test_grounded_pin_display.sv
`timescale 1ns/1ps
module test_grounded_pin_display;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_n = 8'hFF;
  logic [7:0] seg;
  logic       valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  grounded_pin_display i_grounded_pin_display (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pins_ni(pins_n),
    .seg_o  (seg),
    .valid_o(valid)
  );

  // reference model: queue of sampled pin vectors, two-edge latency (R6)
  logic [7:0] hist [$];
  logic [7:0] exp_seg = 8'h00;
  logic       exp_valid = 1'b0;

  function automatic logic [7:0] ref_pat(input int d);
    logic [7:0] t [8] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07};
    return t[d];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      exp_seg   = 8'h00;
      exp_valid = 1'b0;
    end else begin
      logic [7:0] src;
      logic [7:0] nxt;
      src = (hist.size() >= 2) ? hist[hist.size()-2] : 8'hFF;
      nxt = exp_seg;
      for (int k = 7; k >= 0; k--) if (!src[k]) nxt = ref_pat(k); // lowest wins (R3)
      exp_valid = (nxt != exp_seg);
      exp_seg   = nxt;
      hist.push_back(pins_n);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (seg !== exp_seg) begin
        errors++;
        $display("FAIL R2/R3/R4/R6 seg_o: actual=%h expected=%h at %0t", seg, exp_seg, $time);
      end
      checks++;
      if (valid !== exp_valid) begin
        errors++;
        $display("FAIL R7 valid_o: actual=%b expected=%b at %0t", valid, exp_valid, $time);
      end
      checks++;
      if (seg[7] !== 1'b0) begin
        errors++;
        $display("FAIL R5 seg_o[7]: actual=%b expected=0", seg[7]);
      end
    end
  end

  task automatic drive(input logic [7:0] v, input int cycles);
    @(negedge clk); #1;
    pins_n = v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    checks++;
    if (seg !== 8'h00 || valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s: actual seg=%h valid=%b expected seg=00 valid=0", tag, seg, valid);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("during reset");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("after release");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();                                   // R1
    drive(8'hFF, 4);
    for (int k = 0; k < 8; k++) begin             // R2: every digit alone
      drive(~(8'h01 << k), 4);
      drive(8'hFF, 4);                            // R4: hold while idle
    end
    drive(8'b1010_0111, 5);                       // R3: pins 3,4,6 -> 3
    drive(8'b0000_0000, 5);                       // R3: all -> 0
    drive(8'b0111_1111, 4);                       // pin 7
    drive(8'b0111_1111, 4);                       // R7: same pin, no pulse
    drive(8'hFF, 3);
    drive(8'b0111_1111, 3);                       // R7: regrounded, no pulse
    drive(8'b1110_1111, 1);                       // R8: one-edge pulse, pin 4
    drive(8'hFF, 5);
    drive(8'b1101_1011, 1);                       // R8 + R3: pins 2,5 brief
    drive(8'hFF, 5);
    for (int k = 0; k < 40; k++) begin            // R6: fast-changing patterns
      drive(8'((k * 37 + 11) ^ (k << 3)) | ((k % 3 == 0) ? 8'hFF : 8'h00), 1);
    end
    drive(8'hFF, 5);
    drive(8'b1111_1101, 3);                       // digit 1 then reset mid-run
    do_reset();                                   // R1 again
    drive(8'hFF, 4);
    drive(8'b1011_1111, 4);                       // pin 6 after reset
    drive(8'hFF, 4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule